// File: doc/BRIEF.md
# DMA Channel RAM Address Bank

This block holds the internal-RAM address of each of six DMA channels. The CPU loads and reads the addresses through a plain 16-bit register bus. The transfer engine tells the block when a channel has finished one transfer. The channel's address then steps forward by the size of that transfer, unless the channel's hold input is set. Each channel's current offset goes out toward the transfer engine. The block also compares each address against the RAM windows that are legal DMA targets and flags any address that falls outside them.

Each channel stores a 14-bit offset. The block forms the RAM address as `MAP_BASE` plus that offset, modulo 2^16. The parameter `RAM_CFG` selects which windows are legal for that address.

The CPU bus is a single-cycle register port with no back-pressure, and every access completes in the cycle it is presented. `cpu_sel` marks an access and `cpu_we` selects a write. `cpu_hw` marks a 16-bit access. Read data is valid in the same cycle as the access.

Top module: `dma_ram_addr_bank`

## Requirements
- R1: Channel n (n = 0 to 5) answers at bus address 0x182 + 0x10*n. A 16-bit write (`cpu_sel`=1, `cpu_we`=1, `cpu_hw`=1) loads `cpu_wdata[13:0]` into that channel's offset at the next clock edge. A 16-bit read (`cpu_sel`=1, `cpu_we`=0, `cpu_hw`=1) returns the offset in bits 13:0 of `cpu_rdata` in the same cycle.
- R2: Bits 15 and 14 of `cpu_rdata` always read 0. Writes to those bits are discarded.
- R3: When `xfer_done[n]`=1 and `hold[n]`=0, the offset of channel n grows by 1 if `xfer_wide[n]`=0 (8-bit transfer) and by 2 if `xfer_wide[n]`=1 (16-bit transfer).
- R4: When `hold[n]`=1, a completion pulse on channel n leaves its offset unchanged.
- R5: The increment wraps modulo 2^14. For example, 0x3FFF+1 gives 0x0000 and 0x3FFF+2 gives 0x0001.
- R6: If a CPU write and a completion pulse reach the same channel in the same cycle, the written value is loaded and the increment is lost.
- R7: The following accesses are ignored: a byte access (`cpu_hw`=0), an odd address, and an address that selects no channel. Such an access writes nothing and its read returns 0.
- R8: `range_err[n]` is 1 when A = (`MAP_BASE` + offset) mod 2^16 lies outside the legal windows for `RAM_CFG`. The windows are:
  - `RAM_CFG`=0: 0xC000 to 0xEFFF.
  - `RAM_CFG`=1: 0xB000 to 0xEFFF.
  - `RAM_CFG`=2: 0xA000 to 0xBFFF and 0xE000 to 0xEFFF.
  - `RAM_CFG`=3: 0x9000 to 0xBFFF and 0xE000 to 0xEFFF.
- R9: `cur_ofs[14n+13:14n]` always shows the current offset of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It clears the offsets to 0; software must not rely on this value. |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_hw | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| cpu_addr | input | 12 | Bus byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid in the same cycle as the access |
| xfer_done | input | 6 | Per-channel transfer-complete pulse |
| xfer_wide | input | 6 | Per-channel transfer width: 1 for 16-bit, 0 for 8-bit |
| hold | input | 6 | Per-channel address hold |
| cur_offs | output | 84 | Packed current offsets, 14 bits per channel |
| range_err | output | 6 | Per-channel flag: address outside the legal windows |

## Verification
The hardest states to reach from the ports are the collisions and the edges. Collisions are a CPU write landing in the same cycle as a completion pulse on that channel. Edges are an offset sitting at the top of the 14-bit space, or exactly on a window boundary, when an increment arrives. The bench reaches each one by loading the offset first through a legal write: 0x3FFF for the wrap, and 0x0FFF, 0x1000, 0x2FFF and 0x3000 for the window edges. It then drives the completion pulse alone, or together with a write in one cycle. Ignored accesses are checked afterwards by reading the targeted channel back through a legal access.

// File: rtl/dma_ram_addr_pkg.sv
package dma_ram_addr_pkg;

  // Legal DMA target windows for each RAM configuration code.
  function automatic logic addr_in_window(input logic [15:0] a, input logic [1:0] cfg);
    logic ok;
    case (cfg)
      2'd0:    ok = (a >= 16'hC000) && (a <= 16'hEFFF);
      2'd1:    ok = (a >= 16'hB000) && (a <= 16'hEFFF);
      2'd2:    ok = ((a >= 16'hA000) && (a <= 16'hBFFF)) ||
                    ((a >= 16'hE000) && (a <= 16'hEFFF));
      default: ok = ((a >= 16'h9000) && (a <= 16'hBFFF)) ||
                    ((a >= 16'hE000) && (a <= 16'hEFFF));
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h182,
  parameter int STRIDE = 'h10,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic              cpu_hw,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              acc_ok,
  output logic [CH_W-1:0]   acc_ch,
  output logic [NCH-1:0]    wr_en
);

  logic hit;

  always_comb begin
    hit    = 1'b0;
    acc_ch = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cpu_addr == ADDR_W'(BASE + i * STRIDE)) begin
        hit    = 1'b1;
        acc_ch = CH_W'(i);
      end
    end
    acc_ok = cpu_sel && cpu_hw && hit;
    wr_en  = '0;
    for (int i = 0; i < NCH; i++)
      wr_en[i] = acc_ok && cpu_we && (acc_ch == CH_W'(i));
  end

  // R7: a byte access never reaches any channel register
  assert_no_byte_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_hw) |-> (wr_en == '0));

  // R1: at most one channel is written per access
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_ram_addr_pkg::*;
#(
  parameter int           OFS_W    = 14,
  parameter logic [1:0]   RAM_CFG  = 2'd2,
  parameter logic [15:0]  MAP_BASE = 16'h9000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wdata,
  input  logic             xfer_done,
  input  logic             xfer_wide,
  input  logic             hold,
  output logic [OFS_W-1:0] ofs,
  output logic             range_err
);

  logic [OFS_W-1:0] step;
  logic [15:0]      mapped;

  assign step   = xfer_wide ? OFS_W'(2) : OFS_W'(1);
  assign mapped = MAP_BASE + 16'(ofs);

  always_ff @(posedge clk) begin
    if (!rst_n)                 ofs <= '0;
    else if (wr_en)             ofs <= wdata;
    else if (xfer_done && !hold) ofs <= ofs + step;
  end

  assign range_err = !addr_in_window(mapped, RAM_CFG);

  // R6: CPU write wins over a same-cycle completion
  assert_write_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && xfer_done) |=> (ofs == $past(wdata)));

  // R3: step by transfer width
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && !hold) |=>
      (ofs == $past(ofs) + ($past(xfer_wide) ? OFS_W'(2) : OFS_W'(1))));

  // R4: hold freezes the offset
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (hold || !xfer_done)) |=> $stable(ofs));

  // R5: narrow step from the top wraps to zero
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && !hold && !xfer_wide && (ofs == '1)) |=> (ofs == '0));

endmodule

// File: rtl/dma_ram_addr_bank.sv
module dma_ram_addr_bank #(
  parameter int          NCH      = 6,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 16,
  parameter int          OFS_W    = 14,
  parameter logic [1:0]  RAM_CFG  = 2'd2,
  parameter logic [15:0] MAP_BASE = 16'h9000,
  localparam int         CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_sel,
  input  logic               cpu_we,
  input  logic               cpu_hw,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic [NCH-1:0]     xfer_done,
  input  logic [NCH-1:0]     xfer_wide,
  input  logic [NCH-1:0]     hold,
  output logic [NCH*OFS_W-1:0] cur_offs,
  output logic [NCH-1:0]     range_err
);

  logic             acc_ok;
  logic [CH_W-1:0]  acc_ch;
  logic [NCH-1:0]   wr_en;
  logic [OFS_W-1:0] ofs_arr [NCH];

  dma_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_hw(cpu_hw), .cpu_addr(cpu_addr), .acc_ok(acc_ok),
    .acc_ch(acc_ch), .wr_en(wr_en)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_addr_chan #(.OFS_W(OFS_W), .RAM_CFG(RAM_CFG), .MAP_BASE(MAP_BASE)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wdata(cpu_wdata[OFS_W-1:0]),
      .xfer_done(xfer_done[g]), .xfer_wide(xfer_wide[g]), .hold(hold[g]),
      .ofs(ofs_arr[g]), .range_err(range_err[g])
    );
    assign cur_offs[g*OFS_W +: OFS_W] = ofs_arr[g];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (acc_ok && !cpu_we && (acc_ch == CH_W'(i)))
        cpu_rdata = DATA_W'(ofs_arr[i]);
  end

  // R2: unused upper read bits stay zero
  assert_rdata_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[DATA_W-1:OFS_W] == '0);

  // R7: byte reads return zero
  assert_byte_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !cpu_hw) |-> (cpu_rdata == '0));

endmodule

// File: tb/sim_dma_ram_addr_bank.sv
module sim_dma_ram_addr_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_sel = 0, cpu_we = 0, cpu_hw = 0;
  logic [11:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [5:0]  xfer_done = '0, xfer_wide = '0, hold = '0;
  logic [83:0] cur_offs;
  logic [5:0]  range_err;

  int total = 0, bad = 0;
  bit finished = 0;
  int    exp_q[$];
  string tag_q[$];
  logic [13:0] model [6];

  dma_ram_addr_bank u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [11:0] ch_addr(input int n);
    return 12'(12'h182 + n * 12'h10);
  endfunction

  function automatic logic exp_err(input logic [13:0] o);
    logic [15:0] a;
    a = 16'h9000 + 16'(o);
    return !(((a >= 16'hA000) && (a <= 16'hBFFF)) || ((a >= 16'hE000) && (a <= 16'hEFFF)));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design answers
  always @(negedge clk) begin
    if (cpu_sel && !cpu_we && exp_q.size() > 0) begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, int'(cpu_rdata), e);
    end
  end

  task automatic cycle(input logic s, input logic w, input logic h, input logic [11:0] a,
                       input logic [15:0] d, input logic [5:0] dn, input logic [5:0] wd,
                       input logic [5:0] hl);
    cpu_sel = s; cpu_we = w; cpu_hw = h; cpu_addr = a; cpu_wdata = d;
    xfer_done = dn; xfer_wide = wd; hold = hl;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_we = 0; cpu_hw = 0; xfer_done = '0; xfer_wide = '0; hold = '0;
  endtask

  task automatic wr(input int n, input logic [15:0] d);
    cycle(1, 1, 1, ch_addr(n), d, '0, '0, '0);
    model[n] = d[13:0];
  endtask

  task automatic rd(input logic [11:0] a, input logic h, input int e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cycle(1, 0, h, a, '0, '0, '0, '0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("reset idle rdata R7", int'(cpu_rdata), 0);

    // R1 / R9: load and read back every channel
    for (int n = 0; n < 6; n++) wr(n, 16'(16'h1000 + n * 16'h111));
    for (int n = 0; n < 6; n++) begin
      rd(ch_addr(n), 1, int'(model[n]), $sformatf("R1 readback ch%0d", n));
      chk($sformatf("R9 cur_offs ch%0d", n), int'(cur_offs[n*14 +: 14]), int'(model[n]));
    end

    // R2: upper bits dropped
    wr(0, 16'hFFFF);
    rd(ch_addr(0), 1, 16'h3FFF, "R2 upper bits zero");

    // R3: narrow and wide steps
    cycle(0, 0, 0, '0, '0, 6'b000010, 6'b000000, '0); model[1] += 1;
    rd(ch_addr(1), 1, int'(model[1]), "R3 narrow step");
    cycle(0, 0, 0, '0, '0, 6'b000100, 6'b000100, '0); model[2] += 2;
    rd(ch_addr(2), 1, int'(model[2]), "R3 wide step");

    // R4: hold
    cycle(0, 0, 0, '0, '0, 6'b001000, 6'b001000, 6'b001000);
    rd(ch_addr(3), 1, int'(model[3]), "R4 hold keeps offset");

    // R5: wrap
    cycle(0, 0, 0, '0, '0, 6'b000001, 6'b000001, '0);
    rd(ch_addr(0), 1, 16'h0001, "R5 wide wrap");
    wr(0, 16'h3FFF);
    cycle(0, 0, 0, '0, '0, 6'b000001, 6'b000000, '0);
    rd(ch_addr(0), 1, 16'h0000, "R5 narrow wrap");

    // R6: write beats completion
    cycle(1, 1, 1, ch_addr(4), 16'h2222, 6'b010000, 6'b010000, '0); model[4] = 14'h2222;
    rd(ch_addr(4), 1, 16'h2222, "R6 write priority");

    // R7: ignored accesses
    cycle(1, 1, 0, ch_addr(5), 16'h0ABC, '0, '0, '0);
    rd(ch_addr(5), 1, int'(model[5]), "R7 byte write ignored");
    rd(ch_addr(5), 0, 0, "R7 byte read zero");
    cycle(1, 1, 1, 12'h183, 16'h0ABC, '0, '0, '0);
    rd(ch_addr(0), 1, 0, "R7 odd write ignored");
    rd(12'h183, 1, 0, "R7 odd read zero");
    rd(12'h1E2, 1, 0, "R7 unmapped read zero");

    // R8: window edges on channel 5
    wr(5, 16'h0FFF); chk("R8 0x0FFF err", int'(range_err[5]), int'(exp_err(14'h0FFF)));
    wr(5, 16'h1000); chk("R8 0x1000 ok", int'(range_err[5]), int'(exp_err(14'h1000)));
    wr(5, 16'h2FFF); chk("R8 0x2FFF ok", int'(range_err[5]), int'(exp_err(14'h2FFF)));
    cycle(0, 0, 0, '0, '0, 6'b100000, 6'b000000, '0);
    chk("R8 0x3000 after step err", int'(range_err[5]), int'(exp_err(14'h3000)));
    chk("R9 cur_offs ch5", int'(cur_offs[5*14 +: 14]), 16'h3000);

    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule